// File: doc/BRIEF.md
# Compare-and-Swap Pair Legality Decoder

This block sits in the decode stage of a hart and looks at instruction words from the atomic major opcode. It recognises the compare-and-swap family and settles, in one registered stage, whether the word is a legal compare-and-swap on this hart. For a legal word it reports the operand width and whether the operands are register pairs. It also gives the register indices that the register-file read and write ports must use for the low and high halves of the destination (the expected value, which is also the result) and of the swap value.

Legality depends on two things: the hart width, set by the `XLEN` parameter (32 or 64), and the operand width selected by the word. The double-width form needs even register pairs on a 32-bit hart and uses single registers on a 64-bit hart. The quad-width form needs even pairs on a 64-bit hart and does not exist on a 32-bit hart. A pair based at register 0 maps its high half to register 0 as well. Reads of that pair therefore return zero for both halves, and writes to it are discarded. Reading the register file and executing the operation belong to other blocks.

Top module: `cas_pair_decoder`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_is_cas`, `out_legal`, `out_illegal` and `out_paired` are 0, `out_fault` is 0, `out_width` is 3 and every index output is 0.
- R2: Each output reflects the word presented one clock earlier: `out_valid` equals the previous cycle's `in_valid`. A word is a compare-and-swap only when opcode bits [6:0] are 0101111 and bits [31:27] are 00101. Any other word gives `out_is_cas`=0, `out_legal`=0, `out_illegal`=0, `out_fault`=0, `out_width`=3 and all indices 0.
- R3: Bits [14:12] = 010 select the word form, which is legal on both hart widths. It gives `out_width`=0 and `out_paired`=0, with `out_rd_lo` = bits [11:7], `out_rs2_lo` = bits [24:20], and both high indices 0.
- R4: Bits [14:12] = 011 select the double form, `out_width`=1. On a 64-bit hart it is unpaired and behaves as in R3. On a 32-bit hart it is paired.
- R5: Bits [14:12] = 100 select the quad form. On a 64-bit hart it is paired with `out_width`=2. On a 32-bit hart it is illegal with `out_fault`=1.
- R6: Any value of bits [14:12] other than 010, 011 or 100 is illegal with `out_fault`=1.
- R7: In a paired form, an odd destination index (bit 7) or an odd swap-value index (bit 20) is illegal with `out_fault`=2. A width fault takes priority over a parity fault.
- R8: In a legal paired form with an even base b, the low index is b and the high index is b+1. A base of 0 gives a high index of 0.
- R9: An illegal word gives `out_legal`=0, `out_illegal`=1, `out_paired`=0, `out_width`=3 and all indices 0. `out_legal` and `out_illegal` are never both 1.
- R10: Bits [26:25] (ordering flags) and bits [19:15] (address register) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction word is presented this cycle |
| in_instr | input | 32 | Instruction word |
| out_valid | output | 1 | Decode result is valid |
| out_is_cas | output | 1 | Word belongs to the compare-and-swap family |
| out_legal | output | 1 | Legal compare-and-swap on this hart |
| out_illegal | output | 1 | Raise illegal-instruction |
| out_fault | output | 2 | 0 none, 1 bad width, 2 odd pair base |
| out_width | output | 2 | 0 word, 1 double, 2 quad, 3 none |
| out_paired | output | 1 | Operands occupy register pairs |
| out_rd_lo | output | 5 | Destination low-half index |
| out_rd_hi | output | 5 | Destination high-half index |
| out_rs2_lo | output | 5 | Swap-value low-half index |
| out_rs2_hi | output | 5 | Swap-value high-half index |

## Verification
The assertions assume that `in_valid` and `in_instr` are free of unknowns at every clock edge, and that `in_instr` may hold any 32-bit pattern. Outputs are only judged while `out_valid` is high. The bench drives both inputs on the falling edge and never leaves them undriven. It mixes directed words for each width, hart width and register parity with random words whose opcode and function fields are forced into the family about half the time. Two instances, one per hart width, see the same stream.

// File: rtl/cas_dec_pkg.sv
package cas_dec_pkg;

  localparam int ILEN  = 32;
  localparam int REG_W = 5;
  localparam int F3_W  = 3;

  localparam logic [6:0] OPC_ATOMIC = 7'b0101111;
  localparam logic [4:0] FN_CAS     = 5'b00101;

  typedef enum logic [1:0] {
    CW_WORD   = 2'd0,
    CW_DOUBLE = 2'd1,
    CW_QUAD   = 2'd2,
    CW_NONE   = 2'd3
  } cas_width_e;

  typedef enum logic [1:0] {
    FC_NONE  = 2'd0,
    FC_WIDTH = 2'd1,
    FC_ODD   = 2'd2
  } cas_fault_e;

  typedef struct packed {
    logic [6:0]       opcode;
    logic [4:0]       funct5;
    logic [F3_W-1:0]  funct3;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs2;
  } cas_fields_t;

  // Width selected by the function field, CW_NONE when unassigned.
  function automatic cas_width_e width_from_f3(input logic [F3_W-1:0] f3);
    case (f3)
      3'b010:  return CW_WORD;
      3'b011:  return CW_DOUBLE;
      3'b100:  return CW_QUAD;
      default: return CW_NONE;
    endcase
  endfunction

  // Whether a width exists on a hart of the given register width.
  function automatic logic width_exists(input cas_width_e w, input int xlen);
    case (w)
      CW_WORD, CW_DOUBLE: return 1'b1;
      CW_QUAD:            return (xlen == 64);
      default:            return 1'b0;
    endcase
  endfunction

  // An operand wider than the hart register occupies an even pair.
  function automatic logic needs_pair(input cas_width_e w, input int xlen);
    case (w)
      CW_DOUBLE: return (xlen == 32);
      CW_QUAD:   return (xlen == 64);
      default:   return 1'b0;
    endcase
  endfunction

  // High half of an even pair; a zero base stays on the zero register.
  function automatic logic [REG_W-1:0] pair_high(input logic [REG_W-1:0] base);
    if (base == '0) return '0;
    return base | {{(REG_W-1){1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/cas_field_split.sv
module cas_field_split
  import cas_dec_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output cas_fields_t     fields,
  output logic            family_hit
);

  // Ordering flags and address register play no part in legality.
  logic unused_ignored_bits;
  assign unused_ignored_bits = ^{instr[26:25], instr[19:15]};

  always_comb begin
    fields.opcode = instr[6:0];
    fields.funct5 = instr[31:27];
    fields.funct3 = instr[14:12];
    fields.rd     = instr[11:7];
    fields.rs2    = instr[24:20];
  end

  assign family_hit = (fields.opcode == OPC_ATOMIC) && (fields.funct5 == FN_CAS);

endmodule

// File: rtl/cas_width_check.sv
module cas_width_check
  import cas_dec_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [F3_W-1:0] funct3,
  output cas_width_e      width,
  output logic            width_ok,
  output logic            pair_req
);

  always_comb begin
    width    = width_from_f3(funct3);
    width_ok = width_exists(width, XLEN);
    pair_req = width_ok && needs_pair(width, XLEN);
  end

endmodule

// File: rtl/cas_pair_map.sv
module cas_pair_map
  import cas_dec_pkg::*;
(
  input  logic [REG_W-1:0] base,
  input  logic             paired,
  output logic [REG_W-1:0] idx_lo,
  output logic [REG_W-1:0] idx_hi,
  output logic             odd_base
);

  always_comb begin
    idx_lo   = base;
    odd_base = paired && base[0];
    if (paired) idx_hi = pair_high(base);
    else        idx_hi = '0;
  end

endmodule

// File: rtl/cas_pair_decoder.sv
module cas_pair_decoder
  import cas_dec_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ILEN-1:0]  in_instr,
  output logic             out_valid,
  output logic             out_is_cas,
  output logic             out_legal,
  output logic             out_illegal,
  output logic [1:0]       out_fault,
  output logic [1:0]       out_width,
  output logic             out_paired,
  output logic [REG_W-1:0] out_rd_lo,
  output logic [REG_W-1:0] out_rd_hi,
  output logic [REG_W-1:0] out_rs2_lo,
  output logic [REG_W-1:0] out_rs2_hi
);

  // Named internal events, also used by the bound checker.
  cas_fields_t      fld;
  logic             family_hit;
  cas_width_e       width_w;
  logic             width_ok;
  logic             pair_req;
  logic [REG_W-1:0] rd_lo_w, rd_hi_w, rs2_lo_w, rs2_hi_w;
  logic             rd_odd, rs2_odd;
  logic             fault_width, fault_odd;
  logic             legal_w;
  cas_fault_e       fault_w;

  cas_field_split u_split (
    .instr      (in_instr),
    .fields     (fld),
    .family_hit (family_hit)
  );

  cas_width_check #(.XLEN(XLEN)) u_width (
    .funct3   (fld.funct3),
    .width    (width_w),
    .width_ok (width_ok),
    .pair_req (pair_req)
  );

  cas_pair_map u_map_rd (
    .base     (fld.rd),
    .paired   (pair_req),
    .idx_lo   (rd_lo_w),
    .idx_hi   (rd_hi_w),
    .odd_base (rd_odd)
  );

  cas_pair_map u_map_rs2 (
    .base     (fld.rs2),
    .paired   (pair_req),
    .idx_lo   (rs2_lo_w),
    .idx_hi   (rs2_hi_w),
    .odd_base (rs2_odd)
  );

  always_comb begin
    fault_width = family_hit && !width_ok;
    fault_odd   = family_hit && width_ok && (rd_odd || rs2_odd);
    legal_w     = family_hit && !fault_width && !fault_odd;
    if (fault_width)    fault_w = FC_WIDTH;
    else if (fault_odd) fault_w = FC_ODD;
    else                fault_w = FC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_is_cas  <= 1'b0;
      out_legal   <= 1'b0;
      out_illegal <= 1'b0;
      out_fault   <= FC_NONE;
      out_width   <= CW_NONE;
      out_paired  <= 1'b0;
      out_rd_lo   <= '0;
      out_rd_hi   <= '0;
      out_rs2_lo  <= '0;
      out_rs2_hi  <= '0;
    end else begin
      out_valid   <= in_valid;
      out_is_cas  <= family_hit;
      out_legal   <= legal_w;
      out_illegal <= fault_width || fault_odd;
      out_fault   <= fault_w;
      out_width   <= legal_w ? width_w : CW_NONE;
      out_paired  <= legal_w && pair_req;
      out_rd_lo   <= legal_w ? rd_lo_w  : '0;
      out_rd_hi   <= legal_w ? rd_hi_w  : '0;
      out_rs2_lo  <= legal_w ? rs2_lo_w : '0;
      out_rs2_hi  <= legal_w ? rs2_hi_w : '0;
    end
  end

endmodule

// File: rtl/cas_pair_decoder_chk.sv
module cas_pair_decoder_chk
  import cas_dec_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [ILEN-1:0]  in_instr,
  input logic             out_valid,
  input logic             out_is_cas,
  input logic             out_legal,
  input logic             out_illegal,
  input logic [1:0]       out_fault,
  input logic [1:0]       out_width,
  input logic             out_paired,
  input logic [REG_W-1:0] out_rd_lo,
  input logic [REG_W-1:0] out_rd_hi,
  input logic [REG_W-1:0] out_rs2_lo,
  input logic [REG_W-1:0] out_rs2_hi,
  input logic             family_hit,
  input logic             fault_width,
  input logic             fault_odd
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_cas) |-> (!out_legal && !out_illegal && out_fault == 2'd0));

  a_r3_word_unpaired: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_legal && out_width == 2'd0) |-> (!out_paired && out_rd_hi == '0 && out_rs2_hi == '0));

  a_r5_quad_needs_wide_hart: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_legal) |-> (XLEN == 64 || out_width != 2'd2));

  a_r6_bad_f3_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_instr[6:0] == 7'b0101111 && in_instr[31:27] == 5'b00101 &&
     (in_instr[14:12] < 3'b010 || in_instr[14:12] > 3'b100))
    |=> (out_illegal && out_fault == 2'd1));

  a_r7_pair_even: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_paired) |-> (!out_rd_lo[0] && !out_rs2_lo[0]));

  a_r7_single_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_width && fault_odd));

  a_r8_high_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_paired && out_rd_lo != '0) |-> (out_rd_hi == out_rd_lo + 5'd1));

  a_r8_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_paired && out_rs2_lo == '0) |-> (out_rs2_hi == '0));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_legal && out_illegal));

  a_r9_illegal_clean: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (!out_paired && out_width == 2'd3 && out_rd_lo == '0 &&
                     out_rd_hi == '0 && out_rs2_lo == '0 && out_rs2_hi == '0));

  a_r9_illegal_from_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (family_hit && (fault_width || fault_odd)) |=> out_illegal);

endmodule

bind cas_pair_decoder cas_pair_decoder_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_instr    (in_instr),
  .out_valid   (out_valid),
  .out_is_cas  (out_is_cas),
  .out_legal   (out_legal),
  .out_illegal (out_illegal),
  .out_fault   (out_fault),
  .out_width   (out_width),
  .out_paired  (out_paired),
  .out_rd_lo   (out_rd_lo),
  .out_rd_hi   (out_rd_hi),
  .out_rs2_lo  (out_rs2_lo),
  .out_rs2_hi  (out_rs2_hi),
  .family_hit  (family_hit),
  .fault_width (fault_width),
  .fault_odd   (fault_odd)
);

// File: tb/cas_pair_decoder_bench.sv
module cas_pair_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;

  always #4 clk = ~clk;  // 125 MHz

  typedef struct packed {
    logic       is_cas;
    logic       legal;
    logic       illegal;
    logic [1:0] fault;
    logic [1:0] width;
    logic       paired;
    logic [4:0] rd_lo;
    logic [4:0] rd_hi;
    logic [4:0] rs2_lo;
    logic [4:0] rs2_hi;
  } res_t;

  typedef struct {
    res_t  exp;
    string tag;
  } item_t;

  res_t w64, w32;
  logic v64, v32;

  cas_pair_decoder #(.XLEN(64)) u_cas_pair_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .out_valid(v64), .out_is_cas(w64.is_cas), .out_legal(w64.legal),
    .out_illegal(w64.illegal), .out_fault(w64.fault), .out_width(w64.width),
    .out_paired(w64.paired), .out_rd_lo(w64.rd_lo), .out_rd_hi(w64.rd_hi),
    .out_rs2_lo(w64.rs2_lo), .out_rs2_hi(w64.rs2_hi)
  );

  cas_pair_decoder #(.XLEN(32)) u_cas_pair_decoder_rv32 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .out_valid(v32), .out_is_cas(w32.is_cas), .out_legal(w32.legal),
    .out_illegal(w32.illegal), .out_fault(w32.fault), .out_width(w32.width),
    .out_paired(w32.paired), .out_rd_lo(w32.rd_lo), .out_rd_hi(w32.rd_hi),
    .out_rs2_lo(w32.rs2_lo), .out_rs2_hi(w32.rs2_hi)
  );

  item_t q64[$];
  item_t q32[$];
  int    applied = 0;
  int    miscompares = 0;
  bit    done = 1'b0;

  function automatic logic [31:0] enc(input logic [4:0] f5, input logic [1:0] ord,
                                      input logic [4:0] rs2, input logic [4:0] rs1,
                                      input logic [2:0] f3, input logic [4:0] rd,
                                      input logic [6:0] opc);
    return {f5, ord, rs2, rs1, f3, rd, opc};
  endfunction

  // Reference written from the requirements, table-free.
  function automatic res_t model(input logic [31:0] w, input int xlen);
    res_t r;
    bit   cas, pair;
    int   wd;
    r = '0;
    r.width = 2'd3;
    cas = (w[6:0] == 7'h2f) && (w[31:27] == 5'd5);
    r.is_cas = cas;
    if (!cas) return r;
    wd = (w[14:12] == 3'd2) ? 0 : (w[14:12] == 3'd3) ? 1 :
         (w[14:12] == 3'd4 && xlen == 64) ? 2 : -1;
    if (wd < 0) begin
      r.illegal = 1'b1; r.fault = 2'd1; return r;
    end
    pair = (wd == 1 && xlen == 32) || (wd == 2);
    if (pair && (w[7] || w[20])) begin
      r.illegal = 1'b1; r.fault = 2'd2; return r;
    end
    r.legal  = 1'b1;
    r.width  = 2'(wd);
    r.paired = pair;
    r.rd_lo  = w[11:7];
    r.rs2_lo = w[24:20];
    if (pair) begin
      r.rd_hi  = (w[11:7]  == 5'd0) ? 5'd0 : w[11:7]  + 5'd1;
      r.rs2_hi = (w[24:20] == 5'd0) ? 5'd0 : w[24:20] + 5'd1;
    end
    return r;
  endfunction

  task automatic drive(input logic [31:0] w, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = w;
    it.tag = tag;
    it.exp = model(w, 64); q64.push_back(it);
    it.exp = model(w, 32); q32.push_back(it);
  endtask

  task automatic compare(input res_t got, input item_t it, input string hart);
    applied++;
    if (got !== it.exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", it.tag, hart, got, it.exp);
    end
  endtask

  // Monitor: pops one expected item per valid result.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && v64) begin
        if (q64.size() == 0) begin
          miscompares++; $display("FAIL R2 rv64: unexpected valid, got 1 expected 0");
        end else compare(w64, q64.pop_front(), "rv64");
      end
      if (rst_n && v32) begin
        if (q32.size() == 0) begin
          miscompares++; $display("FAIL R2 rv32: unexpected valid, got 1 expected 0");
        end else compare(w32, q32.pop_front(), "rv32");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  localparam logic [6:0] OPA = 7'b0101111;
  localparam logic [4:0] FCAS = 5'b00101;

  initial begin
    res_t rst_exp;
    rst_exp = '0; rst_exp.width = 2'd3;
    in_instr = enc(FCAS, 2'd0, 5'd4, 5'd1, 3'b010, 5'd6, OPA);
    in_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    applied++;
    if (v64 !== 1'b0 || w64 !== rst_exp || v32 !== 1'b0 || w32 !== rst_exp) begin
      miscompares++;
      $display("FAIL R1: got %b/%h expected 0/%h", v64, w64, rst_exp);
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R2 idle: no valid after an idle cycle
    @(negedge clk);
    applied++;
    if (v64 !== 1'b0 || v32 !== 1'b0) begin
      miscompares++; $display("FAIL R2: got %b expected 0", v64);
    end

    drive(enc(5'b00001, 2'd0, 5'd4, 5'd1, 3'b010, 5'd6, OPA), "R2 other funct5");
    drive(enc(FCAS, 2'd0, 5'd4, 5'd1, 3'b010, 5'd6, 7'b0110011), "R2 other opcode");
    drive(enc(FCAS, 2'd0, 5'd9, 5'd3, 3'b010, 5'd13, OPA), "R3 word odd regs");
    drive(enc(FCAS, 2'd0, 5'd0, 5'd3, 3'b010, 5'd31, OPA), "R3 word");
    drive(enc(FCAS, 2'd0, 5'd10, 5'd3, 3'b011, 5'd12, OPA), "R4 double even");
    drive(enc(FCAS, 2'd0, 5'd11, 5'd3, 3'b011, 5'd12, OPA), "R4 R7 double odd rs2");
    drive(enc(FCAS, 2'd0, 5'd30, 5'd3, 3'b011, 5'd0, OPA), "R4 R8 double zero rd");
    drive(enc(FCAS, 2'd0, 5'd8, 5'd3, 3'b100, 5'd16, OPA), "R5 quad even");
    drive(enc(FCAS, 2'd0, 5'd0, 5'd3, 3'b100, 5'd0, OPA), "R5 R8 quad zero pair");
    drive(enc(FCAS, 2'd0, 5'd8, 5'd3, 3'b100, 5'd17, OPA), "R5 R7 quad odd rd");
    drive(enc(FCAS, 2'd0, 5'd30, 5'd3, 3'b100, 5'd30, OPA), "R8 top pair");
    for (int f = 0; f < 8; f++)
      drive(enc(FCAS, 2'd0, 5'd7, 5'd3, 3'(f), 5'd5, OPA), "R6 R7 funct3 sweep");
    for (int o = 0; o < 4; o++) begin
      drive(enc(FCAS, 2'(o), 5'd2, 5'd0,  3'b011, 5'd4, OPA), "R10 ordering bits");
      drive(enc(FCAS, 2'(o), 5'd2, 5'd31, 3'b100, 5'd4, OPA), "R10 address reg");
    end
    // gap in valid, then R2 latency resumes
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 600; i++) begin
      logic [31:0] w;
      w = $urandom;
      if ($urandom_range(0, 1) == 1) begin
        w[6:0] = OPA; w[31:27] = FCAS;
      end
      drive(w, "R3 R4 R5 R6 R7 R9 random");
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk); in_valid = 1'b0;
      end
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    if (q64.size() != 0 || q32.size() != 0) begin
      miscompares++;
      $display("FAIL R2: got %0d pending expected 0", q64.size() + q32.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule